// File: doc/BRIEF.md
# BCD Calendar Register File

This block is a 64-byte register file behind a bus shaped like an asynchronous SRAM. The bus has a 6-bit address, separate 8-bit input and output data paths, and active-low chip select, output enable and write enable. A system clock samples all bus inputs. Eight of the addresses are BCD timekeeping fields: hundredths, seconds, minutes, hours, day of week, date, month and year. These fields step forward on a single-cycle 100 Hz strobe. The remaining addresses hold alarm bytes, a binary command byte, the watchdog value and general storage.

The counting is done on an internal copy of the time. Software reads a separate visible copy, and the internal copy is moved into it in one transfer. While a read cycle is open the transfer is held back, so software that reads several bytes in one cycle sees a single instant of time. A write to a time field loads both copies. A power-fail input rejects every bus write but does not stop the counters.

Top module: `rtc_regfile`

## Requirements
- R1: While cs_ni and oe_ni are low and we_ni is high, data_o carries the addressed byte. Otherwise data_o is 8'h00.
- R2: A write cycle is the span of clock edges where cs_ni and we_ni are both low. It commits at the first edge where either one is high, using the address and data sampled at the last edge of the cycle.
- R3: A write is discarded if pfail_i is high at any edge of its cycle or at its commit edge. The counters keep advancing while pfail_i is high.
- R4: Each tick_i advances hundredths (address 0x0) in BCD. Going from 99 to 00 carries into seconds (0x1). Seconds going from 59 to 00 carries into minutes (0x2), and minutes going from 59 to 00 carries into hours.
- R5: Hours live at address 0x4. When bit 6 is 0 the clock is in 24-hour mode and bits 5:0 count 00 to 23. Going from 23 to 00 advances day of week (0x6, counting 1 to 7 with 7 wrapping to 1) and date (0x8).
- R6: When bit 6 of 0x4 is 1 the clock is in 12-hour mode. Bit 5 is PM and bits 4:0 count 01 to 12. Going from 11 to 12 toggles PM, and going from 12 to 01 keeps it. Going from 11 PM to 12 AM advances the date.
- R7: Date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other long months, advancing month (0x9). Month 12 wraps to 01 and advances year (0xA). Year 99 wraps to 00.
- R8: February holds 29 days when the BCD year is divisible by 4 and 28 days otherwise.
- R9: The visible time bytes do not change while a read cycle stays open. One edge after the read closes, they equal the internal counters.
- R10: A write to a time address loads the internal counter. Later ticks count on from the written value, and the tick at the commit edge is dropped.
- R11: Every address other than the eight time fields stores the written byte and returns it on read. This covers alarms at 0x3, 0x5 and 0x7, command at 0xB, watchdog at 0xC and 0xD, and storage at 0xE to 0x3F.
- R12: After reset the time reads as 00:00:00.00 in 24-hour mode, with day 1, date 01, month 01 and year 00. All other bytes read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz strobe, one cycle wide |
| pfail_i | input | 1 | Power-fail; blocks writes |
| cs_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 6 | Register address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, 00 when not reading |

## Verification
A wrong internal counter is not visible at the ports until the transfer copies it. That happens one edge after any edge with no read open, so a corrupted carry shows up on the very next read of the affected byte. The directed scenarios therefore place the counters just before each rollover (hundredths, the hour in both modes, month ends, leap February, year end). One tick later they read back every field the carry should touch. A broken freeze or a misplaced write commit shows up as a read that returns the old or the new value one transfer too early.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_HS   = 6'h00;
  localparam logic [ADDR_W-1:0] A_SEC  = 6'h01;
  localparam logic [ADDR_W-1:0] A_MIN  = 6'h02;
  localparam logic [ADDR_W-1:0] A_HR   = 6'h04;
  localparam logic [ADDR_W-1:0] A_DOW  = 6'h06;
  localparam logic [ADDR_W-1:0] A_DATE = 6'h08;
  localparam logic [ADDR_W-1:0] A_MON  = 6'h09;
  localparam logic [ADDR_W-1:0] A_YR   = 6'h0A;

  typedef struct packed {
    logic [DATA_W-1:0] yr;
    logic [DATA_W-1:0] mon;
    logic [DATA_W-1:0] date;
    logic [DATA_W-1:0] dow;
    logic [DATA_W-1:0] hr;
    logic [DATA_W-1:0] min;
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] hs;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                     hr: 8'h00, min: 8'h00, sec: 8'h00, hs: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  // BCD year divisible by 4: even tens -> 0/4/8, odd tens -> 2/6
  function automatic logic leap_yr(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_yr(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic is_time(input logic [ADDR_W-1:0] a);
    return (a == A_HS) || (a == A_SEC) || (a == A_MIN) || (a == A_HR) ||
           (a == A_DOW) || (a == A_DATE) || (a == A_MON) || (a == A_YR);
  endfunction

  function automatic logic [7:0] get_field(input rtc_time_t t, input logic [ADDR_W-1:0] a);
    case (a)
      A_HS:    return t.hs;
      A_SEC:   return t.sec;
      A_MIN:   return t.min;
      A_HR:    return t.hr;
      A_DOW:   return t.dow;
      A_DATE:  return t.date;
      A_MON:   return t.mon;
      A_YR:    return t.yr;
      default: return 8'h00;
    endcase
  endfunction

  function automatic rtc_time_t put_field(input rtc_time_t t, input logic [ADDR_W-1:0] a,
                                          input logic [7:0] d);
    rtc_time_t r;
    r = t;
    case (a)
      A_HS:    r.hs   = d;
      A_SEC:   r.sec  = d;
      A_MIN:   r.min  = d;
      A_HR:    r.hr   = d;
      A_DOW:   r.dow  = d;
      A_DATE:  r.date = d;
      A_MON:   r.mon  = d;
      A_YR:    r.yr   = d;
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  output rtc_time_t nxt_o
);
  logic day_c;

  always_comb begin
    nxt_o = cur_i;
    day_c = 1'b0;
    nxt_o.hs = (cur_i.hs == 8'h99) ? 8'h00 : bcd_inc(cur_i.hs);
    if (cur_i.hs == 8'h99) begin
      nxt_o.sec = (cur_i.sec == 8'h59) ? 8'h00 : bcd_inc(cur_i.sec);
      if (cur_i.sec == 8'h59) begin
        nxt_o.min = (cur_i.min == 8'h59) ? 8'h00 : bcd_inc(cur_i.min);
        if (cur_i.min == 8'h59) begin
          if (!cur_i.hr[6]) begin
            day_c    = (cur_i.hr[5:0] == 6'h23);
            nxt_o.hr = {cur_i.hr[7:6], 6'h00} |
                       (day_c ? 8'h00 : (bcd_inc({2'b00, cur_i.hr[5:0]}) & 8'h3F));
          end else if (cur_i.hr[4:0] == 5'h12) begin
            nxt_o.hr = {cur_i.hr[7:5], 5'h01};
          end else if (cur_i.hr[4:0] == 5'h11) begin
            nxt_o.hr = {cur_i.hr[7:6], ~cur_i.hr[5], 5'h12};
            day_c    = cur_i.hr[5];
          end else begin
            nxt_o.hr = {cur_i.hr[7:5], 5'h00} | (bcd_inc({3'b000, cur_i.hr[4:0]}) & 8'h1F);
          end
        end
      end
    end
    if (day_c) begin
      nxt_o.dow = (cur_i.dow == 8'h07) ? 8'h01 : cur_i.dow + 8'h01;
      if (cur_i.date == month_len(cur_i.mon, cur_i.yr)) begin
        nxt_o.date = 8'h01;
        if (cur_i.mon == 8'h12) begin
          nxt_o.mon = 8'h01;
          nxt_o.yr  = (cur_i.yr == 8'h99) ? 8'h00 : bcd_inc(cur_i.yr);
        end else begin
          nxt_o.mon = bcd_inc(cur_i.mon);
        end
      end else begin
        nxt_o.date = bcd_inc(cur_i.date);
      end
    end
  end
endmodule

// File: rtl/rtc_bus_ctl.sv
module rtc_bus_ctl
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              pfail_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_act_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic wr_now, wr_q, abort_q;

  assign wr_now   = !cs_ni && !we_ni;
  assign rd_act_o = !cs_ni && !oe_ni && we_ni;
  assign commit_o = wr_q && !wr_now && !abort_q && !pfail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      abort_q <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      wr_q    <= wr_now;
      abort_q <= wr_now && (pfail_i || (wr_q && abort_q));
      if (wr_now) begin
        waddr_o <= addr_i;
        wdata_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pfail_i,
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  logic              rd_act, wr_commit;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  rtc_time_t         int_q, vis_q, nxt;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              wr_time;

  rtc_bus_ctl u_bus (
    .clk_i, .rst_ni, .cs_ni, .oe_ni, .we_ni, .pfail_i, .addr_i, .data_i,
    .rd_act_o (rd_act),
    .commit_o (wr_commit),
    .waddr_o  (waddr),
    .wdata_o  (wdata)
  );

  rtc_advance u_adv (.cur_i(int_q), .nxt_o(nxt));

  assign wr_time = wr_commit && is_time(waddr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= TIME_RST;
      vis_q <= TIME_RST;
    end else begin
      if (wr_time)     int_q <= put_field(int_q, waddr, wdata);
      else if (tick_i) int_q <= nxt;
      // transfer held while a read is open
      if (wr_time)      vis_q <= put_field(int_q, waddr, wdata);
      else if (!rd_act) vis_q <= int_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_commit && !wr_time) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_comb begin
    data_o = '0;
    if (rd_act) data_o = is_time(addr_i) ? get_field(vis_q, addr_i) : mem_q[addr_i];
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              pfail_i,
  input logic              cs_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              commit_i,
  input rtc_time_t         int_i,
  input rtc_time_t         vis_i
);
  logic rd;
  assign rd = !cs_ni && !oe_ni && we_ni;

  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> data_o == 8'h00);

  p_commit_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(!cs_ni && !we_ni) && (cs_ni || we_ni));

  p_commit_pwr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !pfail_i && !$past(pfail_i));

  p_hs_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !commit_i && int_i.hs == 8'h99) |=> int_i.hs == 8'h00);

  p_dow_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !commit_i && int_i.hs == 8'h99 && int_i.sec == 8'h59 && int_i.min == 8'h59 &&
     int_i.hr == 8'h23 && int_i.dow == 8'h07) |=> int_i.dow == 8'h01);

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && $past(rd)) |-> $stable(vis_i));
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .pfail_i  (pfail_i),
  .cs_ni    (cs_ni),
  .oe_ni    (oe_ni),
  .we_ni    (we_ni),
  .data_o   (data_o),
  .commit_i (wr_commit),
  .int_i    (int_q),
  .vis_i    (vis_q)
);

// File: tb/tb_rtc_regfile.sv
module tb_rtc_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, pfail = 1'b0;
  logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  int         checks = 0, fails = 0, cyc = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  rtc_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pfail_i(pfail),
    .cs_ni(cs_n), .oe_ni(oe_n), .we_ni(we_n), .addr_i(addr), .data_i(din), .data_o(dout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; cs_n = 0; we_n = 0;
    @(negedge clk); @(negedge clk); cs_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; cs_n = 0; oe_n = 0;
    #2 d = dout;
    @(negedge clk); cs_n = 1; oe_n = 1;
  endtask

  task automatic expect_rd(input string req, input logic [5:0] a, input logic [7:0] e);
    logic [7:0] d;
    bus_rd(a, d);
    chk(req, d, e);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] hr, input logic [7:0] dow, input logic [7:0] date,
                          input logic [7:0] mon, input logic [7:0] yr);
    bus_wr(6'h00, 8'h99); bus_wr(6'h01, 8'h59); bus_wr(6'h02, 8'h59);
    bus_wr(6'h04, hr); bus_wr(6'h06, dow); bus_wr(6'h08, date);
    bus_wr(6'h09, mon); bus_wr(6'h0A, yr);
  endtask

  task automatic t_reset;
    expect_rd("R12 hs", 6'h00, 8'h00);
    expect_rd("R12 hr", 6'h04, 8'h00);
    expect_rd("R12 dow", 6'h06, 8'h01);
    expect_rd("R12 date", 6'h08, 8'h01);
    expect_rd("R12 mon", 6'h09, 8'h01);
    expect_rd("R12 yr", 6'h0A, 8'h00);
    expect_rd("R12 ram", 6'h20, 8'h00);
    #1 chk("R1 idle", dout, 8'h00);
  endtask

  task automatic t_storage;
    bus_wr(6'h03, 8'h45); bus_wr(6'h0B, 8'hA5); bus_wr(6'h0D, 8'h37); bus_wr(6'h3F, 8'h5C);
    expect_rd("R11 alarm", 6'h03, 8'h45);
    expect_rd("R11 cmd", 6'h0B, 8'hA5);
    expect_rd("R11 wdog", 6'h0D, 8'h37);
    expect_rd("R11 ram top", 6'h3F, 8'h5C);
    @(negedge clk); addr = 6'h3F; cs_n = 0; oe_n = 1;
    #2 chk("R1 oe high", dout, 8'h00);
    cs_n = 1; oe_n = 0;
    #1 chk("R1 cs high", dout, 8'h00);
    oe_n = 1;
  endtask

  task automatic t_write_end;
    @(negedge clk); addr = 6'h21; din = 8'h11; cs_n = 0; we_n = 0;
    @(negedge clk); din = 8'h22;
    @(negedge clk); cs_n = 1; we_n = 1;
    @(negedge clk);
    expect_rd("R2 last data", 6'h21, 8'h22);
  endtask

  task automatic t_pfail;
    pfail = 1;
    bus_wr(6'h10, 8'h77);
    pfail = 0;
    expect_rd("R3 write blocked", 6'h10, 8'h00);
    @(negedge clk); addr = 6'h11; din = 8'h55; cs_n = 0; we_n = 0;
    @(negedge clk); pfail = 1;
    @(negedge clk); pfail = 0;
    @(negedge clk); cs_n = 1; we_n = 1;
    @(negedge clk);
    expect_rd("R3 mid abort", 6'h11, 8'h00);
    bus_wr(6'h00, 8'h05);
    pfail = 1;
    bus_wr(6'h00, 8'h50);
    tick_n(1);
    expect_rd("R3 keeps time", 6'h00, 8'h06);
    pfail = 0;
  endtask

  task automatic t_seconds;
    bus_wr(6'h00, 8'h99); bus_wr(6'h01, 8'h58); bus_wr(6'h02, 8'h12);
    tick_n(1);
    expect_rd("R4 hs wrap", 6'h00, 8'h00);
    expect_rd("R10 sec from written", 6'h01, 8'h59);
    expect_rd("R4 min held", 6'h02, 8'h12);
    bus_wr(6'h00, 8'h99);
    tick_n(1);
    expect_rd("R4 sec wrap", 6'h01, 8'h00);
    expect_rd("R4 min carry", 6'h02, 8'h13);
    bus_wr(6'h00, 8'h09);
    tick_n(2);
    expect_rd("R10 hs count", 6'h00, 8'h11);
  endtask

  task automatic t_24h;
    set_time(8'h23, 8'h07, 8'h15, 8'h03, 8'h21);
    tick_n(1);
    expect_rd("R5 hr wrap", 6'h04, 8'h00);
    expect_rd("R5 dow wrap", 6'h06, 8'h01);
    expect_rd("R5 date", 6'h08, 8'h16);
    expect_rd("R5 min", 6'h02, 8'h00);
  endtask

  task automatic t_12h;
    set_time(8'h51, 8'h02, 8'h10, 8'h03, 8'h21);
    tick_n(1);
    expect_rd("R6 11am->12pm", 6'h04, 8'h72);
    expect_rd("R6 no date step", 6'h08, 8'h10);
    set_time(8'h72, 8'h02, 8'h10, 8'h03, 8'h21);
    tick_n(1);
    expect_rd("R6 12->01 pm", 6'h04, 8'h61);
    set_time(8'h71, 8'h02, 8'h10, 8'h03, 8'h21);
    tick_n(1);
    expect_rd("R6 11pm->12am", 6'h04, 8'h52);
    expect_rd("R6 date step", 6'h08, 8'h11);
    expect_rd("R6 dow step", 6'h06, 8'h03);
  endtask

  task automatic t_months;
    set_time(8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
    tick_n(1);
    expect_rd("R7 apr end date", 6'h08, 8'h01);
    expect_rd("R7 apr end mon", 6'h09, 8'h05);
    set_time(8'h23, 8'h01, 8'h30, 8'h05, 8'h21);
    tick_n(1);
    expect_rd("R7 may 31", 6'h08, 8'h31);
    set_time(8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    tick_n(1);
    expect_rd("R7 dec date", 6'h08, 8'h01);
    expect_rd("R7 dec mon", 6'h09, 8'h01);
    expect_rd("R7 yr wrap", 6'h0A, 8'h00);
  endtask

  task automatic t_leap;
    set_time(8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    tick_n(1);
    expect_rd("R8 leap 29", 6'h08, 8'h29);
    expect_rd("R8 leap mon", 6'h09, 8'h02);
    set_time(8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    tick_n(1);
    expect_rd("R8 leap end", 6'h09, 8'h03);
    set_time(8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    tick_n(1);
    expect_rd("R8 common date", 6'h08, 8'h01);
    expect_rd("R8 common mon", 6'h09, 8'h03);
    set_time(8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    tick_n(1);
    expect_rd("R8 year 00", 6'h08, 8'h29);
  endtask

  task automatic t_freeze;
    bus_wr(6'h00, 8'h10);
    @(negedge clk); addr = 6'h00; cs_n = 0; oe_n = 0;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk); @(negedge clk);
    #2 chk("R9 frozen", dout, 8'h10);
    @(negedge clk); cs_n = 1; oe_n = 1;
    @(negedge clk);
    expect_rd("R9 after read", 6'h00, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_storage;
    t_write_end;
    t_pfail;
    t_seconds;
    t_24h;
    t_12h;
    t_months;
    t_leap;
    t_freeze;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule